// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Peripheral Handoff

This block controls 32 pads from a single-cycle register port. Each pad has three pieces of state: an output latch bit, a direction bit and an ownership bit. The pads are grouped in banks of eight, and each bank sits in the low byte of its own 32-bit register word. A pad owned by the GPIO logic is driven from its latch, and its enable comes from its direction bit. A pad handed to a peripheral takes both its level and its enable straight from that peripheral.

Software claims a pad by clearing its ownership bit. It updates single pads by read-modify-write of whole words, so every stored bit must read back exactly. Reading the data word does not return the latch. It returns the pad level after a two-flop synchronizer, whatever the pad's direction. Because the latch holds its value in both directions, software can preload a level before it turns a pad into an output.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset every ownership bit is 1, every direction bit is 0 and every latch bit is 0. Each ownership word reads 0x000000FF and each direction word reads 0.
- R2: Pin n sits at bit (n mod 8) of word (n div 8) inside its group. The word addresses are 0–3 for data, 4–7 for direction and 8–11 for ownership (byte offsets 0x00, 0x10 and 0x20).
- R3: On a GPIO-owned pin, pad_oe_o is 1 when the direction bit is 1 (output) and 0 when it is 0 (input).
- R4: When a pin's ownership bit is 1, pad_out_o and pad_oe_o follow per_out_i and per_oe_i for that pin. When the bit is 0, they follow the latch and the direction bit.
- R5: Writes to the direction or ownership words leave the latch unchanged. A level written while the pin is an input appears on pad_out_o as soon as the pin becomes an output.
- R6: The direction and ownership words read back exactly the low byte last written to them.
- R7: Bits 31:8 of every read are 0, and wdata bits 31:8 have no effect.
- R8: Word addresses 12–15 read as 0, and writes to them change no state.
- R9: A pad change first shows in a data read whose select is sampled at the third rising edge after the change. Reads sampled at the first and second edges return the old level.
- R10: rdata_o is loaded on the edge that samples a read select and holds its value through writes and idle cycles.
- R11: A data-word read returns the synchronized pad level and not the latch, for input pins and output pins alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read select |
| pad_i | input | 32 | Pad input levels (asynchronous) |
| per_out_i | input | 32 | Peripheral output levels |
| per_oe_i | input | 32 | Peripheral output enables |
| pad_out_o | output | 32 | Level driven to each pad |
| pad_oe_o | output | 32 | Output enable of each pad |

## Verification
Two things are hard to observe from the ports. The first is the exact synchronizer latency. The bench holds a pad pattern stable, then changes it in the same cycle that a continuous read select starts, and compares the rdata of three back-to-back reads against the old, old and new levels. The second is that the latch survives direction changes while a data read still shows the pad rather than the latch. To check this, the bench drives the pads with a pattern that differs from the latch and compares the pad outputs and the read data after each direction flip.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    GRP_DATA = 2'd0,
    GRP_DIR  = 2'd1,
    GRP_FUNC = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // groups are laid out back to back, one word per bank
  function automatic grp_e grp_of(input int unsigned word_idx, input int unsigned banks);
    if (word_idx < banks)          return GRP_DATA;
    else if (word_idx < 2 * banks) return GRP_DIR;
    else if (word_idx < 3 * banks) return GRP_FUNC;
    else                           return GRP_NONE;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 8,
  localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W,
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  grp_e                  grp_i,
  input  logic [BANK_IDX_W-1:0] bank_i,
  input  logic [BANK_W-1:0]     wbyte_i,
  output logic [NUM_PINS-1:0]   data_q_o,
  output logic [NUM_PINS-1:0]   dir_q_o,
  output logic [NUM_PINS-1:0]   func_q_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = we_i && (bank_i == BANK_IDX_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q_o[b*BANK_W +: BANK_W] <= '0;
        dir_q_o[b*BANK_W +: BANK_W]  <= '0;
        func_q_o[b*BANK_W +: BANK_W] <= '1;  // peripheral owns every pad out of reset
      end else if (hit) begin
        case (grp_i)
          GRP_DATA: data_q_o[b*BANK_W +: BANK_W] <= wbyte_i;
          GRP_DIR:  dir_q_o[b*BANK_W +: BANK_W]  <= wbyte_i;
          GRP_FUNC: func_q_o[b*BANK_W +: BANK_W] <= wbyte_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/1ps
module gpio_pad_mux #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] data_q_i,
  input  logic [NUM_PINS-1:0] dir_q_i,
  input  logic [NUM_PINS-1:0] func_q_i,
  input  logic [NUM_PINS-1:0] per_out_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      if (func_q_i[p]) begin
        pad_out_o[p] = per_out_i[p];
        pad_oe_o[p]  = per_oe_i[p];
      end else begin
        pad_out_o[p] = data_q_i[p];
        pad_oe_o[p]  = dir_q_i[p];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_mux.sv
`timescale 1ns/1ps
module gpio_bank_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] per_out_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int unsigned NUM_BANKS  = NUM_PINS / BANK_W;
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  grp_e                  grp;
  logic [BANK_IDX_W-1:0] bank_sel;
  logic                  we;
  logic                  re;
  logic [NUM_PINS-1:0]   pad_sync;
  logic [NUM_PINS-1:0]   data_q;
  logic [NUM_PINS-1:0]   dir_q;
  logic [NUM_PINS-1:0]   func_q;
  logic [BANK_W-1:0]     rd_byte;
  logic                  unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:BANK_W];

  assign grp      = grp_of(32'(addr_i), NUM_BANKS);
  assign bank_sel = BANK_IDX_W'(addr_i % ADDR_W'(NUM_BANKS));
  assign we       = sel_i && wr_i && (grp != GRP_NONE);
  assign re       = sel_i && !wr_i;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (pad_sync)
  );

  gpio_bank_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .grp_i   (grp),
    .bank_i  (bank_sel),
    .wbyte_i (wdata_i[BANK_W-1:0]),
    .data_q_o(data_q),
    .dir_q_o (dir_q),
    .func_q_o(func_q)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .data_q_i (data_q),
    .dir_q_i  (dir_q),
    .func_q_i (func_q),
    .per_out_i(per_out_i),
    .per_oe_i (per_oe_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  // data group reads the pad, not the latch
  always_comb begin
    rd_byte = '0;
    case (grp)
      GRP_DATA: rd_byte = pad_sync[bank_sel*BANK_W +: BANK_W];
      GRP_DIR:  rd_byte = dir_q[bank_sel*BANK_W +: BANK_W];
      GRP_FUNC: rd_byte = func_q[bank_sel*BANK_W +: BANK_W];
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (re)  rdata_o <= {{(BUS_W-BANK_W){1'b0}}, rd_byte};
  end
endmodule

// File: rtl/gpio_bank_mux_chk.sv
`timescale 1ns/1ps
module gpio_bank_mux_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sel_i,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [BUS_W-1:0]    wdata_i,
  input logic [BUS_W-1:0]    rdata_o,
  input logic [NUM_PINS-1:0] pad_i,
  input logic [NUM_PINS-1:0] sync_q,
  input logic [NUM_PINS-1:0] data_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] func_q
);
  localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W;

  logic              dir_wr, oob, last_dir_wr;
  int unsigned       last_bank;
  logic [BANK_W-1:0] last_byte;
  logic [1:0]        since_rst;

  assign dir_wr = sel_i && wr_i && (32'(addr_i) >= NUM_BANKS) && (32'(addr_i) < 2 * NUM_BANKS);
  assign oob    = 32'(addr_i) >= 3 * NUM_BANKS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_dir_wr <= 1'b0;
      last_bank   <= 0;
      last_byte   <= '0;
      since_rst   <= '0;
    end else begin
      last_dir_wr <= dir_wr;
      last_bank   <= 32'(addr_i) - NUM_BANKS;
      last_byte   <= wdata_i[BANK_W-1:0];
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
  end

  a_r6_dir_write_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_dir_wr |-> dir_q[last_bank*BANK_W +: BANK_W] == last_byte);

  a_r5_latch_kept_on_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> $stable(data_q));

  a_r8_oob_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && oob) |=> ($stable(data_q) && $stable(dir_q) && $stable(func_q)));

  a_r8_oob_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && oob) |=> rdata_o == '0);

  a_r9_two_stage_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> sync_q == $past(pad_i, 2));

  a_r10_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !wr_i) |=> $stable(rdata_o));
endmodule

bind gpio_bank_mux gpio_bank_mux_chk #(
  .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pad_i  (pad_i),
  .sync_q (pad_sync),
  .data_q (data_q),
  .dir_q  (dir_q),
  .func_q (func_q)
);

// File: tb/gpio_bank_mux_tb.sv
`timescale 1ns/1ps
module gpio_bank_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pad = '0, per_out = '0, per_oe = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_data [4];
  logic [7:0] m_dir  [4];
  logic [7:0] m_func [4];

  always #2.5 clk = ~clk;

  gpio_bank_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .per_out_i(per_out),
    .per_oe_i(per_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
    if (a < 4)       m_data[a]     = d[7:0];
    else if (a < 8)  m_dir[a - 4]  = d[7:0];
    else if (a < 12) m_func[a - 8] = d[7:0];
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    d = rdata;
  endtask

  function automatic logic [31:0] exp_out();
    logic [31:0] r;
    for (int n = 0; n < 32; n++)
      r[n] = m_func[n/8][n%8] ? per_out[n] : m_data[n/8][n%8];
    return r;
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] r;
    for (int n = 0; n < 32; n++)
      r[n] = m_func[n/8][n%8] ? per_oe[n] : m_dir[n/8][n%8];
    return r;
  endfunction

  task automatic check_pads(input string req);
    check({req, " pad_out"}, pad_out, exp_out());
    check({req, " pad_oe"},  pad_oe,  exp_oe());
  endtask

  task automatic check_all_words(input string req);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      bus_read(w[3:0], d);
      if (w < 4)       check({req, " data word"}, d, {24'h0, pad[w*8 +: 8]});
      else if (w < 8)  check({req, " dir word"},  d, {24'h0, m_dir[w-4]});
      else if (w < 12) check({req, " func word"}, d, {24'h0, m_func[w-8]});
      else             check({req, " oob word"},  d, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, held;
    for (int b = 0; b < 4; b++) begin m_data[b] = 8'h00; m_dir[b] = 8'h00; m_func[b] = 8'hFF; end
    per_out = 32'hC3A5_0F96; per_oe = 32'h5A5A_F00F; pad = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, R4 peripheral ownership
    check_pads("R1 R4 reset");
    check_all_words("R1 R8 reset");

    // R2 walking pin mapping: take every pin for GPIO, inputs
    for (int b = 0; b < 4; b++) bus_write(4'(8 + b), 32'h0);
    for (int n = 0; n < 32; n++) begin
      bus_write(4'(n / 8), 32'h1 << (n % 8));
      check("R2 walking latch bit", pad_out, 32'h1 << n);
      check("R3 input pins no oe", pad_oe, 32'h0);
      bus_write(4'(n / 8), 32'h0);
    end

    // R5 preload then switch to output; R11 read shows pad not latch
    pad = 32'h0000_005A;
    bus_write(4'd0, 32'hFFFF_FF3C);
    check("R5 latch preloaded while input", pad_out[7:0], 8'h3C);
    check("R3 still input", pad_oe[7:0], 8'h00);
    bus_write(4'd4, 32'h0000_00FF);
    check("R5 latch kept after dir set", pad_out[7:0], 8'h3C);
    check("R3 output enables", pad_oe[7:0], 8'hFF);
    bus_read(4'd0, d);
    check("R11 data read returns pad in output mode", d, 32'h0000_005A);
    bus_write(4'd4, 32'h0);
    check("R5 latch kept after dir clear", pad_out[7:0], 8'h3C);
    bus_read(4'd0, d);
    check("R11 data read returns pad in input mode", d, 32'h0000_005A);

    // Sweep: R2 R3 R4 R6 R7 R11 under varied patterns
    for (int i = 0; i < 64; i++) begin
      int b;
      logic [7:0] vd, vr, vf;
      b  = i % 4;
      vd = 8'((i * 53 + 7) & 255);
      vr = 8'((i * 29 + 3) & 255);
      vf = 8'((i * 101 + 91) & 255);
      per_out = 32'h9E37_79B9 * (i + 1);
      per_oe  = {per_out[15:0], per_out[31:16]} ^ 32'(i * 7919);
      pad     = ~{per_out[7:0], per_out[31:8]};
      bus_write(4'(b),     {8'(i), 16'hBEEF, vd});
      bus_write(4'(4 + b), {16'hA5C3, 8'(i), vr});
      bus_write(4'(8 + b), {24'hFFFFFF, vf});
      bus_read(4'(4 + b), d);
      check("R6 R7 dir readback", d, {24'h0, vr});
      bus_read(4'(8 + b), d);
      check("R6 R7 func readback", d, {24'h0, vf});
      bus_read(4'(b), d);
      check("R11 R7 data read is pad", d, {24'h0, pad[b*8 +: 8]});
      check_pads("R2 R3 R4 sweep");
    end

    // R8 out-of-range writes
    for (int w = 12; w < 16; w++) bus_write(4'(w), 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check_pads("R8 after oob writes");
    check_all_words("R8 state unchanged");

    // R9 synchronizer latency
    pad = 32'h0000_0011;
    repeat (4) @(negedge clk);
    pad = 32'h0000_00EE;
    sel = 1; wr = 0; addr = 4'd0;
    @(negedge clk);
    check("R9 first edge old level", rdata, 32'h11);
    @(negedge clk);
    check("R9 second edge old level", rdata, 32'h11);
    @(negedge clk);
    check("R9 third edge new level", rdata, 32'hEE);
    sel = 0;

    // R10 rdata holds through writes and idle
    bus_read(4'd9, held);
    pad = 32'h0000_0077;
    bus_write(4'd5, 32'h0000_0042);
    repeat (4) @(negedge clk);
    check("R10 rdata held", rdata, held);
    bus_read(4'd5, d);
    check("R10 R6 new read loads", d, 32'h42);

    finish_run();
  end
endmodule